// File: doc/BRIEF.md
# Timer Channel Trigger and Clock Gating

This block is the core of one channel of a general-purpose timer/counter. It holds a 16-bit counter, the latch that turns the counter clock on and off, and the logic that restarts the count. The counter advances on a one-cycle tick that marks the active edge of the selected counter clock. It counts only while the clock latch is on and no stop event is pending.

Four sources restart the count: a per-channel software strobe, a sync strobe that a block-level write drives to all channels at once, a match between the counter and a compare value, and an event on an external pin. The pin source depends on the mode. The block does not apply a restart at once. It holds the request and applies it at the next counter-clock tick, so the count can stay non-zero for some cycles after a trigger.

A mode bit chooses capture or waveform operation. The block also produces the output-enable controls for the two channel pins from that bit.

Top module: `tcg_chan_gate`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `cnt` is 0 and `clk_on`, `pin_a_oe` and `pin_b_oe` are 0.
- R2: `clk_en_cmd` sets `clk_on` at the next clock edge. `clk_dis_cmd` or `dis_evt` clears it at the next clock edge. When an enable and a disable arrive in the same cycle, the disable wins.
- R3: On each cycle with `cnt_tick` high, `cnt` goes up by one if `clk_on` is 1, no stop is in force and no trigger is applied. It wraps from 0xFFFF to 0. In every other case `cnt` holds.
- R4: A `sw_trig` pulse is remembered until the next cycle with `cnt_tick` high. At that edge `cnt` becomes 0. Before that edge `cnt` does not change.
- R5: A `sync_in` pulse acts exactly like `sw_trig`.
- R6: With `rc_trig_en` = 1 and the counter running, `cnt` equal to `rc_val` raises a trigger, so the counter returns to 0 at the next tick. With `rc_trig_en` = 0 the match has no effect.
- R7: The external trigger source is chosen as follows. With `wave_mode` = 0, `ext_sel[0]` = 0 selects `pin_a` and 1 selects `pin_b`. With `wave_mode` = 1, `ext_sel` 0, 1, 2 and 3 select `pin_b`, `xc0`, `xc1` and `xc2`. Each pin passes through two synchronizer flops. A rising edge on the synchronized pin is a trigger only while `ext_trig_en` = 1.
- R8: A `stop_evt` pulse halts counting until a trigger is applied at a tick. If `stop_evt` and an applied trigger fall in the same cycle, the stop stays in force.
- R9: One cycle after the inputs, `pin_a_oe` equals `wave_mode`. `pin_b_oe` is 1 only when `wave_mode` = 1 and `ext_sel` is not 0.
- R10: An applied trigger clears `cnt` even while `clk_on` is 0, and it leaves `clk_on` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | One-cycle pulse marking the selected counter-clock edge |
| clk_en_cmd | input | 1 | Clock-enable command strobe |
| clk_dis_cmd | input | 1 | Clock-disable command strobe |
| sw_trig | input | 1 | Software trigger strobe |
| sync_in | input | 1 | Broadcast sync strobe |
| stop_evt | input | 1 | Stop event: halts counting until the next trigger |
| dis_evt | input | 1 | Disable event: clears the clock latch |
| wave_mode | input | 1 | 0 = capture, 1 = waveform |
| ext_sel | input | 2 | External trigger source select |
| ext_trig_en | input | 1 | External trigger enable |
| rc_trig_en | input | 1 | Compare-trigger enable |
| rc_val | input | 16 | Compare value |
| pin_a | input | 1 | Channel pin A (input side) |
| pin_b | input | 1 | Channel pin B (input side) |
| xc0 | input | 1 | External signal 0 |
| xc1 | input | 1 | External signal 1 |
| xc2 | input | 1 | External signal 2 |
| cnt | output | 16 | Counter value |
| clk_on | output | 1 | Clock status latch |
| pin_a_oe | output | 1 | Output enable for pin A |
| pin_b_oe | output | 1 | Output enable for pin B |

## Verification
The bench targets these corner cases:
- A trigger that arrives several cycles before a tick, and one that coincides with a tick. A design that applies triggers at once would show zero too early. One that drops the pending flag would miss the restart.
- Enable and disable in the same cycle, and a stop event in the same cycle as a trigger. Wrong priority leaves the clock running or the count free.
- The compare trigger, which must give a period of `rc_val`+1 ticks and must do nothing when disabled.
- Every external source in both modes, including a rising pin while `ext_trig_en` is 0.
- The 0xFFFF wrap and a trigger while the clock is off. That trigger must clear the count without turning the clock on.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
  localparam int CNT_W    = 16;
  localparam int SYNC_N   = 2;
  localparam int NUM_PINS = 5;
  // bit positions inside the synchronized pin vector
  localparam int P_A  = 0;
  localparam int P_B  = 1;
  localparam int P_X0 = 2;
  localparam int P_X1 = 3;
  localparam int P_X2 = 4;
endpackage

// File: rtl/tcg_pin_sync.sv
module tcg_pin_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  localparam int LAST = STAGES;

  // pipe[0..STAGES-1] synchronize, pipe[STAGES] keeps the prior sample
  logic [LAST:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i <= LAST; i++) pipe[i] <= pipe[i-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_edge
      assign rise[g] = pipe[LAST-1][g] & ~pipe[LAST][g];
    end
  endgenerate
endmodule

// File: rtl/tcg_trig_sel.sv
module tcg_trig_sel
  import tcg_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wave_mode,
  input  logic [1:0]          ext_sel,
  input  logic                ext_trig_en,
  input  logic [NUM_PINS-1:0] rise,
  output logic                ext_evt,
  output logic                pin_a_oe,
  output logic                pin_b_oe
);
  logic src;

  always_comb begin
    if (!wave_mode) begin
      src = ext_sel[0] ? rise[P_B] : rise[P_A];
    end else begin
      unique case (ext_sel)
        2'd0:    src = rise[P_B];
        2'd1:    src = rise[P_X0];
        2'd2:    src = rise[P_X1];
        default: src = rise[P_X2];
      endcase
    end
  end

  assign ext_evt = ext_trig_en & src;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_a_oe <= 1'b0;
      pin_b_oe <= 1'b0;
    end else begin
      pin_a_oe <= wave_mode;
      pin_b_oe <= wave_mode & (ext_sel != 2'd0);
    end
  end
endmodule

// File: rtl/tcg_trig_ctl.sv
module tcg_trig_ctl (
  input  logic clk,
  input  logic rst,
  input  logic cnt_tick,
  input  logic clk_en_cmd,
  input  logic clk_dis_cmd,
  input  logic dis_evt,
  input  logic stop_evt,
  input  logic trig_req,
  output logic clk_on,
  output logic run,
  output logic trig_apply,
  output logic trig_pend
);
  logic stopped;

  assign trig_apply = cnt_tick & (trig_pend | trig_req);
  assign run        = clk_on & ~stopped;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_on    <= 1'b0;
      stopped   <= 1'b0;
      trig_pend <= 1'b0;
    end else begin
      // clock status latch, disable has priority
      if (clk_dis_cmd || dis_evt) clk_on <= 1'b0;
      else if (clk_en_cmd)        clk_on <= 1'b1;

      // stop latch, a new stop beats a same-cycle restart
      if (stop_evt)        stopped <= 1'b1;
      else if (trig_apply) stopped <= 1'b0;

      // a request waits for the next counter-clock tick
      if (cnt_tick)      trig_pend <= 1'b0;
      else if (trig_req) trig_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/tcg_counter.sv
module tcg_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_tick,
  input  logic         run,
  input  logic         trig_apply,
  input  logic [W-1:0] rc_val,
  output logic [W-1:0] cnt,
  output logic         rc_match
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt_tick) begin
      if (trig_apply) cnt <= '0;
      else if (run)   cnt <= cnt + ONE;
    end
  end

  assign rc_match = (cnt == rc_val);
endmodule

// File: rtl/tcg_chan_gate.sv
module tcg_chan_gate
  import tcg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_tick,
  input  logic             clk_en_cmd,
  input  logic             clk_dis_cmd,
  input  logic             sw_trig,
  input  logic             sync_in,
  input  logic             stop_evt,
  input  logic             dis_evt,
  input  logic             wave_mode,
  input  logic [1:0]       ext_sel,
  input  logic             ext_trig_en,
  input  logic             rc_trig_en,
  input  logic [CNT_W-1:0] rc_val,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             xc0,
  input  logic             xc1,
  input  logic             xc2,
  output logic [CNT_W-1:0] cnt,
  output logic             clk_on,
  output logic             pin_a_oe,
  output logic             pin_b_oe
);
  logic [NUM_PINS-1:0] pins_raw;
  logic [NUM_PINS-1:0] pins_rise;
  logic                ext_evt;
  logic                rc_match;
  logic                rc_hit;
  logic                trig_req;
  logic                trig_apply;
  logic                trig_pend;
  logic                run;

  assign pins_raw = {xc2, xc1, xc0, pin_b, pin_a};

  tcg_pin_sync #(.W(NUM_PINS), .STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pins_raw),
    .rise (pins_rise)
  );

  tcg_trig_sel u_sel (
    .clk         (clk),
    .rst         (rst),
    .wave_mode   (wave_mode),
    .ext_sel     (ext_sel),
    .ext_trig_en (ext_trig_en),
    .rise        (pins_rise),
    .ext_evt     (ext_evt),
    .pin_a_oe    (pin_a_oe),
    .pin_b_oe    (pin_b_oe)
  );

  assign rc_hit   = rc_trig_en & rc_match & run;
  assign trig_req = sw_trig | sync_in | ext_evt | rc_hit;

  tcg_trig_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .cnt_tick    (cnt_tick),
    .clk_en_cmd  (clk_en_cmd),
    .clk_dis_cmd (clk_dis_cmd),
    .dis_evt     (dis_evt),
    .stop_evt    (stop_evt),
    .trig_req    (trig_req),
    .clk_on      (clk_on),
    .run         (run),
    .trig_apply  (trig_apply),
    .trig_pend   (trig_pend)
  );

  tcg_counter #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .cnt_tick   (cnt_tick),
    .run        (run),
    .trig_apply (trig_apply),
    .rc_val     (rc_val),
    .cnt        (cnt),
    .rc_match   (rc_match)
  );
endmodule

// File: rtl/tcg_chan_gate_chk.sv
module tcg_chan_gate_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_tick,
  input logic         clk_en_cmd,
  input logic         clk_dis_cmd,
  input logic         dis_evt,
  input logic         sw_trig,
  input logic         wave_mode,
  input logic [1:0]   ext_sel,
  input logic [W-1:0] cnt,
  input logic         clk_on,
  input logic         pin_a_oe,
  input logic         pin_b_oe,
  input logic         run,
  input logic         trig_apply,
  input logic         trig_pend
);
  p_dis_wins_r2: assert property (@(posedge clk) disable iff (rst)
    (clk_dis_cmd || dis_evt) |=> !clk_on);

  p_enable_r2: assert property (@(posedge clk) disable iff (rst)
    (clk_en_cmd && !clk_dis_cmd && !dis_evt) |=> clk_on);

  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
    !cnt_tick |=> $stable(cnt));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick && run && !trig_apply) |=> (cnt == W'($past(cnt) + 1)));

  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick && !run && !trig_apply) |=> $stable(cnt));

  p_trig_zero_r4: assert property (@(posedge clk) disable iff (rst)
    trig_apply |=> (cnt == '0));

  p_pend_r4: assert property (@(posedge clk) disable iff (rst)
    (sw_trig && !cnt_tick) |=> trig_pend);

  p_a_out_r9: assert property (@(posedge clk) disable iff (rst)
    wave_mode |=> pin_a_oe);

  p_a_in_r9: assert property (@(posedge clk) disable iff (rst)
    !wave_mode |=> (!pin_a_oe && !pin_b_oe));

  p_b_in_r9: assert property (@(posedge clk) disable iff (rst)
    (ext_sel == 2'd0) |=> !pin_b_oe);
endmodule

bind tcg_chan_gate tcg_chan_gate_chk #(.W(tcg_pkg::CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cnt_tick    (cnt_tick),
  .clk_en_cmd  (clk_en_cmd),
  .clk_dis_cmd (clk_dis_cmd),
  .dis_evt     (dis_evt),
  .sw_trig     (sw_trig),
  .wave_mode   (wave_mode),
  .ext_sel     (ext_sel),
  .cnt         (cnt),
  .clk_on      (clk_on),
  .pin_a_oe    (pin_a_oe),
  .pin_b_oe    (pin_b_oe),
  .run         (run),
  .trig_apply  (trig_apply),
  .trig_pend   (trig_pend)
);

// File: tb/test_tcg_chan_gate.sv
`timescale 1ns/1ps
module test_tcg_chan_gate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_tick = 0, clk_en_cmd = 0, clk_dis_cmd = 0, sw_trig = 0;
  logic        sync_in = 0, stop_evt = 0, dis_evt = 0, wave_mode = 0;
  logic [1:0]  ext_sel = 0;
  logic        ext_trig_en = 0, rc_trig_en = 0;
  logic [15:0] rc_val = 0;
  logic        pin_a = 0, pin_b = 0, xc0 = 0, xc1 = 0, xc2 = 0;
  logic [15:0] cnt;
  logic        clk_on, pin_a_oe, pin_b_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  string cur_req = "R1";

  // scoreboard: {cnt, clk_on, pin_a_oe, pin_b_oe}
  logic [18:0] exp_q[$];
  string       tag_q[$];

  // reference state
  logic [15:0] m_cnt = 0;
  logic        m_on = 0, m_stop = 0, m_pend = 0;
  logic [4:0]  m_s1 = 0, m_s2 = 0, m_s3 = 0;

  always #2 clk = ~clk;

  tcg_chan_gate i_tcg_chan_gate (
    .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .clk_en_cmd(clk_en_cmd),
    .clk_dis_cmd(clk_dis_cmd), .sw_trig(sw_trig), .sync_in(sync_in),
    .stop_evt(stop_evt), .dis_evt(dis_evt), .wave_mode(wave_mode),
    .ext_sel(ext_sel), .ext_trig_en(ext_trig_en), .rc_trig_en(rc_trig_en),
    .rc_val(rc_val), .pin_a(pin_a), .pin_b(pin_b), .xc0(xc0), .xc1(xc1),
    .xc2(xc2), .cnt(cnt), .clk_on(clk_on), .pin_a_oe(pin_a_oe),
    .pin_b_oe(pin_b_oe)
  );

  task automatic check(string req, logic [18:0] got, logic [18:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {cnt,on,aoe,boe} got %h exp %h", req, got, exp);
    end
  endtask

  // advance the reference by one clock edge from the current inputs
  task automatic model_step();
    logic [4:0]  rise;
    logic        src, hit, req, app, aoe, boe;
    rise = m_s2 & ~m_s3;
    if (!wave_mode) src = ext_sel[0] ? rise[1] : rise[0];
    else case (ext_sel)
      2'd0: src = rise[1];
      2'd1: src = rise[2];
      2'd2: src = rise[3];
      default: src = rise[4];
    endcase
    hit = rc_trig_en && m_on && !m_stop && (m_cnt == rc_val);
    req = sw_trig | sync_in | (ext_trig_en & src) | hit;
    app = cnt_tick && (m_pend || req);
    if (cnt_tick) begin
      if (app) m_cnt = 16'd0;
      else if (m_on && !m_stop) m_cnt = m_cnt + 16'd1;
      m_pend = 1'b0;
    end else if (req) m_pend = 1'b1;
    if (stop_evt) m_stop = 1'b1;
    else if (app) m_stop = 1'b0;
    if (clk_dis_cmd || dis_evt) m_on = 1'b0;
    else if (clk_en_cmd) m_on = 1'b1;
    aoe = wave_mode;
    boe = wave_mode && (ext_sel != 2'd0);
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = {xc2, xc1, xc0, pin_b, pin_a};
    exp_q.push_back({m_cnt, m_on, aoe, boe});
    tag_q.push_back(cur_req);
  endtask

  // driver: called at a falling edge with inputs already set
  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      model_step();
      @(negedge clk);
    end
  endtask

  task automatic ticks(int n);
    cnt_tick = 1'b1; cyc(n); cnt_tick = 1'b0;
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [18:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {cnt, clk_on, pin_a_oe, pin_b_oe}, e);
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got running exp finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wave_mode = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {cnt, clk_on, pin_a_oe, pin_b_oe}, 19'd0);
    wave_mode = 1'b0;
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1", {cnt, clk_on, pin_a_oe, pin_b_oe}, 19'd0);
    @(negedge clk);

    // R3: ticks while clock is off do nothing, then counting
    cur_req = "R3";
    ticks(4);
    clk_en_cmd = 1; cyc(); clk_en_cmd = 0;
    ticks(10);
    for (int i = 0; i < 6; i++) begin cnt_tick = i[0]; cyc(); end
    cnt_tick = 0;

    // R2: enable and disable together, disable event, re-enable
    cur_req = "R2";
    clk_en_cmd = 1; clk_dis_cmd = 1; cyc(); clk_en_cmd = 0; clk_dis_cmd = 0;
    ticks(3);
    clk_en_cmd = 1; cyc(); clk_en_cmd = 0; ticks(2);
    clk_en_cmd = 1; dis_evt = 1; cyc(); clk_en_cmd = 0; dis_evt = 0;
    ticks(2);
    clk_en_cmd = 1; cyc(); clk_en_cmd = 0; ticks(5);

    // R4: software trigger held until the tick
    cur_req = "R4";
    sw_trig = 1; cyc(); sw_trig = 0;
    cyc(3);
    ticks(4);
    sw_trig = 1; cnt_tick = 1; cyc(); sw_trig = 0; cnt_tick = 0;
    ticks(3);

    // R5: sync strobe
    cur_req = "R5";
    sync_in = 1; cyc(); sync_in = 0;
    cyc(2); ticks(3);

    // R10: trigger with clock off
    cur_req = "R10";
    clk_dis_cmd = 1; cyc(); clk_dis_cmd = 0;
    ticks(2);
    sw_trig = 1; cyc(); sw_trig = 0; ticks(3);
    clk_en_cmd = 1; cyc(); clk_en_cmd = 0; ticks(3);

    // R6: compare trigger on and off
    cur_req = "R6";
    rc_val = 16'd5; rc_trig_en = 1;
    ticks(20);
    for (int i = 0; i < 12; i++) begin cnt_tick = (i % 3 == 0); cyc(); end
    cnt_tick = 0;
    rc_trig_en = 0; ticks(12);

    // R8: stop event, restart, stop during a trigger
    cur_req = "R8";
    stop_evt = 1; cyc(); stop_evt = 0;
    ticks(5);
    sw_trig = 1; cyc(); sw_trig = 0; ticks(4);
    stop_evt = 1; sw_trig = 1; cnt_tick = 1; cyc();
    stop_evt = 0; sw_trig = 0; cnt_tick = 0;
    ticks(3);
    sw_trig = 1; cyc(); sw_trig = 0; ticks(3);

    // R7: external sources, capture mode
    cur_req = "R7";
    ext_trig_en = 1; ext_sel = 2'd0; cnt_tick = 1;
    cyc(6); pin_a = 1; cyc(6); pin_a = 0; cyc(3);
    pin_b = 1; cyc(6); pin_b = 0; cyc(3);
    ext_sel = 2'd1; cyc(4); pin_b = 1; cyc(6); pin_b = 0; cyc(3);
    ext_trig_en = 0; cyc(3); pin_b = 1; cyc(6); pin_b = 0; cyc(3);
    ext_trig_en = 1;
    // waveform mode, every selection
    cur_req = "R9";
    wave_mode = 1;
    for (int s = 0; s < 4; s++) begin
      ext_sel = s[1:0];
      cur_req = "R7";
      cyc(4);
      pin_b = (s == 0); xc0 = (s == 1); xc1 = (s == 2); xc2 = (s == 3);
      cyc(6);
      pin_b = 0; xc0 = 0; xc1 = 0; xc2 = 0;
      cyc(3);
      // unselected pin rising: no restart
      pin_a = 1; cyc(6); pin_a = 0; cyc(3);
    end
    cur_req = "R9";
    wave_mode = 0; ext_sel = 2'd3; cyc(3);
    cnt_tick = 0; ext_trig_en = 0;

    // R3: wrap from 0xFFFF to 0
    cur_req = "R3";
    sw_trig = 1; cyc(); sw_trig = 0;
    ticks(65540);
    cyc(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule